// File: doc/BRIEF.md
# Reset-Programmed Field Delay Memory

This block stores a stream of words and plays it back later, like a digital delay line. The write side and the read side each have their own clock. Each side has its own synchronous reset, which sends that side's address pointer back to word zero. There are no full or empty flags. The delay between the two streams comes only from how far apart the two resets land, counted in words. Both pointers run around a ring of `DEPTH` words and wrap silently.

After each reset, that side is busy for a startup window of `STARTUP + 4` of its own clock cycles. A busy output shows this window, and the side does nothing while it lasts. After the window, the side handles one word on every clock edge.

A write-enable low masks the current write. The stored word stays as it was, but the write pointer still steps. A read-enable low skips the current word. The read pointer still steps, the output data holds its last value, and the valid flag drops. A typical use is a field or line delay for video, where the read reset is issued a fixed number of words after the write reset.

Top module: `field_delay_fifo`

## Requirements
- R1: The write clock and read clock are independent and may run at different frequencies; the read stream still reproduces the stored words in address order.
- R2: Either clock may be stopped at any level for any time without loss of stored data; when the clock restarts, the stream resumes at the next address.
- R3: A write reset sets the write pointer to word 0. `wr_busy` then stays high for exactly `STARTUP+4` write clock cycles. During that window no word is stored and the pointer does not move. The first word stored lands at address 0.
- R4: A read reset sets the read pointer to word 0 and drives `rd_valid` low and `rd_data` to zero. `rd_busy` then stays high for exactly `STARTUP+4` read clock cycles, and `rd_valid` stays low while it is high.
- R5: The read stream equals the write stream delayed by the number of words written between the two resets. The first word read after the read reset is the first word stored after the write reset.
- R6: Once busy is low, each rising edge of the write clock advances the write pointer by one word. Each rising edge of the read clock advances the read pointer by one word.
- R7: With `wr_en` low on a non-busy edge, the addressed word keeps its previous contents and the write pointer still advances.
- R8: With `rd_en` low on a non-busy edge, the read pointer advances. `rd_valid` is low after that edge and `rd_data` holds its previous value. With `rd_en` high, `rd_valid` is high after the edge and `rd_data` carries the addressed word.
- R9: Both pointers wrap from `DEPTH-1` back to 0 with no flag or stall, so a stream longer than `DEPTH` words keeps going.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write reset, active high; restarts the write pointer at word 0 |
| wr_en | input | 1 | Write enable; low masks the write on this edge |
| wr_data | input | WIDTH | Word to store |
| wr_busy | output | 1 | High during the write startup window |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous read reset, active high; restarts the read pointer at word 0 |
| rd_en | input | 1 | Read enable; low skips the word on this edge |
| rd_data | output | WIDTH | Last word read, registered |
| rd_valid | output | 1 | High for one cycle after an edge that read a word |
| rd_busy | output | 1 | High during the read startup window |

## Verification
Busy rises one edge after a reset. It is seen high on exactly `STARTUP+4` falling edges, so the first word is taken on the next rising edge after that. `rd_data` and `rd_valid` come from a single register stage, so a read decided on one rising edge shows up right after that edge. The bench therefore sets every input on a falling edge. At the next falling edge it compares the outputs with the result predicted for the rising edge in between. The prediction comes from a word-by-word model of the ring. That model is updated only on edges where the observed busy is low, and its own count of busy cycles is checked separately against `STARTUP+4`.

// File: rtl/field_delay_fifo.sv
module field_delay_fifo #(
  parameter int WIDTH   = 10,
  parameter int DEPTH   = 1024,
  parameter int STARTUP = 16
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_busy,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             rd_busy
);
  localparam int LAT = STARTUP + 4;
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(LAT + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] ring [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    wr_wait, rd_wait;

  assign wr_busy = (wr_wait != '0);
  assign rd_busy = (rd_wait != '0);

  // write side
  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_ptr  <= '0;
      wr_wait <= CW'(LAT);
    end else if (wr_busy) begin
      wr_wait <= wr_wait - CW'(1);
    end else begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (!wr_rst && !wr_busy && wr_en)
      ring[wr_ptr] <= wr_data;
  end

  // read side
  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_ptr   <= '0;
      rd_wait  <= CW'(LAT);
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_busy) begin
      rd_wait  <= rd_wait - CW'(1);
      rd_valid <= 1'b0;
    end else begin
      rd_ptr   <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= ring[rd_ptr];
    end
  end

  assert_wr_reset_R3: assert property (@(posedge wr_clk)
    wr_rst |=> (wr_ptr == '0 && wr_busy));

  assert_wr_hold_busy_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_busy |=> $stable(wr_ptr));

  assert_wr_step_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    !wr_busy |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + AW'(1)));

  assert_rd_reset_R4: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_ptr == '0 && rd_busy && !rd_valid && rd_data == '0));

  assert_rd_quiet_busy_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_busy |=> (!rd_valid && $stable(rd_ptr)));

  assert_rd_step_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_busy |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + AW'(1)));

  assert_skip_hold_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!rd_busy && !rd_en) |=> (!rd_valid && $stable(rd_data)));

  assert_read_valid_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!rd_busy && rd_en) |=> rd_valid);
endmodule

// File: tb/sim_field_delay_fifo.sv
`timescale 1ns/1ps
module sim_field_delay_fifo;
  localparam int W   = 10;
  localparam int D   = 64;
  localparam int SU  = 6;
  localparam int LAT = SU + 4;

  logic wr_clk = 0, rd_clk = 0;
  bit   wr_run = 1, rd_run = 1;
  realtime rd_half = 2.0;

  logic         wr_rst = 1, wr_en = 0, rd_rst = 1, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid, wr_busy, rd_busy;

  int checks = 0, fails = 0;
  string cur_tag = "R5";
  bit mask_on = 0, skip_on = 0, chk_on = 0, have_exp = 0, done = 0;
  bit wr_rst_req = 1, rd_rst_req = 1;
  logic [W-1:0] model [D];
  logic [W-1:0] exp_data = '0;
  logic         exp_valid = 0;
  int wp = 0, rp = 0, wseq = 0, rseq = 0, nread = 0;

  field_delay_fifo #(.WIDTH(W), .DEPTH(D), .STARTUP(SU)) u0 (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data), .wr_busy(wr_busy),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_busy(rd_busy)
  );

  always #2 if (wr_run) wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #(rd_half) if (rd_run) rd_clk = ~rd_clk;
  end

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // write driver and ring model: decide on a falling edge what the next rising edge does
  always @(negedge wr_clk) begin
    if (wr_rst_req) begin
      wr_rst = 1; wr_en = 0; wr_rst_req = 0; wp = 0;
    end else begin
      wr_rst  = 0;
      wr_en   = !(mask_on && (wseq % 5 == 2));
      wr_data = W'(wseq);
      if (wr_busy === 1'b0) begin
        if (wr_en) model[wp] = wr_data;
        wp = (wp + 1) % D;
      end
      wseq++;
    end
  end

  // read driver and checker
  always @(negedge rd_clk) begin
    if (chk_on && have_exp) begin
      check(rd_valid === exp_valid, cur_tag, "rd_valid", int'(rd_valid), int'(exp_valid));
      check(rd_data === exp_data, cur_tag, "rd_data", int'(rd_data), int'(exp_data));
      nread++;
    end
    if (rd_rst_req) begin
      rd_rst = 1; rd_en = 0; rd_rst_req = 0; rp = 0;
      exp_valid = 0; exp_data = '0; have_exp = 1;
    end else begin
      rd_rst = 0;
      rd_en  = !(skip_on && (rseq % 3 == 1));
      if (rd_busy === 1'b0) begin
        if (rd_en) begin
          exp_valid = 1; exp_data = model[rp];
        end else begin
          exp_valid = 0;
        end
        rp = (rp + 1) % D;
      end else begin
        exp_valid = 0;
      end
      rseq++;
    end
  end

  task automatic t_startup();
    int cnt;
    wr_rst_req = 1;
    wait (!wr_rst_req);
    @(negedge wr_clk);
    check(wr_busy === 1'b1, "R3", "wr_busy after reset", int'(wr_busy), 1);
    cnt = 0;
    while (wr_busy === 1'b1) begin cnt++; @(negedge wr_clk); end
    check(cnt == LAT, "R3", "write startup cycles", cnt, LAT);

    rd_rst_req = 1;
    wait (!rd_rst_req);
    @(negedge rd_clk);
    check(rd_busy === 1'b1, "R4", "rd_busy after reset", int'(rd_busy), 1);
    check(rd_valid === 1'b0, "R4", "rd_valid after reset", int'(rd_valid), 0);
    check(rd_data === '0, "R4", "rd_data after reset", int'(rd_data), 0);
    cnt = 0;
    while (rd_busy === 1'b1) begin
      if (rd_valid !== 1'b0) check(0, "R4", "rd_valid while busy", int'(rd_valid), 0);
      cnt++; @(negedge rd_clk);
    end
    check(cnt == LAT, "R4", "read startup cycles", cnt, LAT);
  endtask

  task automatic t_stream(int dly, bit m, bit s, int n, string tag);
    chk_on = 0; mask_on = m; skip_on = s; cur_tag = tag;
    wr_rst_req = 1;
    wait (!wr_rst_req);
    @(negedge wr_clk);
    while (wr_busy === 1'b1 || wp < dly) @(negedge wr_clk);
    rd_rst_req = 1;
    wait (!rd_rst_req);
    nread = 0; chk_on = 1;
    while (nread < n) @(negedge rd_clk);
    chk_on = 0;
  endtask

  task automatic t_pause();
    fork
      t_stream(20, 0, 0, 150, "R2");
      begin
        #200; wr_run = 0; #40; wr_run = 1;
        #100; rd_run = 0; #40; rd_run = 1;
      end
    join
  endtask

  task automatic t_freq();
    rd_half = 2.5;
    t_stream(10, 1, 1, 100, "R1");
    rd_half = 2.0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #300000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    t_startup();
    t_stream(20, 0, 0, 150, "R5");
    t_stream(40, 0, 0, 40, "R6");
    t_stream(20, 1, 0, 120, "R7");
    t_stream(20, 0, 1, 120, "R8");
    t_stream(8, 1, 1, 200, "R9");
    t_pause();
    t_freq();
    done = 1;
    finish_run();
  end
endmodule